// File: doc/BRIEF.md
# Interlocked Request/Acknowledge Word Link

This block carries single-word reads and writes between an initiator and a small target register store. The two sides run on separate clocks and share no timing for the transfer. The only timing is a fully interlocked request/acknowledge exchange with four edges. The initiator owns the bus at all times, so there is no arbitration. A local command (direction, address, write word) is handed to the initiator side. The target side answers each exchange and either stores the word it is given or drives back the word it holds.

One set of shared lines carries both the address and the data, at different phases of a transaction. Every transaction is therefore two complete four-edge exchanges. The first carries the address. Request is held back for a configurable number of initiator cycles after the address appears, so that the target has time to decode it. The second exchange carries the data. Each side passes the handshake line coming from the other side through a two-stage synchroniser before its state machine uses it. When a transaction is over, the initiator gives a one-cycle completion pulse, and for reads the captured word is presented with it.

Top module: `hs_link_top`

## Requirements
- R1: While reset is held, `bus_req`, `bus_ack` and `done` are 0, `bus_ad` is all zeros and `cmd_ready` is 1.
- R2: A command is accepted on a rising `clk_m` edge where `cmd_valid` and `cmd_ready` are both 1. The address then appears on `bus_ad`, zero-extended in the low bits, from that edge onward. `bus_req` rises exactly DECODE_CYC `clk_m` edges later, and DECODE_CYC is at least 1.
- R3: The initiator raises request only after it has seen acknowledge low, and it drops request only after it has seen acknowledge high.
- R4: The target raises acknowledge only after it has seen request high, and it drops acknowledge only after it has seen request low.
- R5: While request is high, the word on `bus_ad` and the direction line `bus_rd` (1 = read, 0 = write) do not change.
- R6: A write stores `cmd_wdata` at `cmd_addr` in the target. During the data exchange, the write word is on `bus_ad` when request rises.
- R7: A read returns the word most recently written to that address, or zero if nothing has been written there since reset. The word appears on `rdata` together with `done`.
- R8: Each transaction makes exactly two rising edges on `bus_req`: the first with the address on `bus_ad`, the second with the data.
- R9: The initiator and the target never drive the shared lines in the same cycle.
- R10: `cmd_ready` is 0 from acceptance until `done`. A `cmd_valid` presented during that time is ignored and leaves the target contents unchanged.
- R11: `done` is a single-cycle pulse. It is raised only after acknowledge is seen low at the end of the data exchange, and `cmd_ready` is 1 again in the cycle that `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Initiator clock |
| rst_m_n | input | 1 | Initiator reset, active low |
| clk_s | input | 1 | Target clock |
| rst_s_n | input | 1 | Target reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Target address |
| cmd_wdata | input | DATA_W | Word to write |
| cmd_ready | output | 1 | Initiator idle, command may be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Word captured by the last read |
| bus_ad | output | DATA_W | Shared address/data lines |
| bus_rd | output | 1 | Direction line, 1 = read |
| bus_req | output | 1 | Request line |
| bus_ack | output | 1 | Acknowledge line |

## Verification
The bench builds the block with ADDR_W = 3, DATA_W = 16 and DECODE_CYC = 4. With only eight addresses, random traffic often reads back a location it has already written, and it also overwrites locations, so stale data would show up. A decode delay of four cycles makes any off-by-one in the delay counter visible as a wrong edge count. The target clock runs at a period that is not a multiple of the initiator period, so the synchroniser latency changes from one exchange to the next.

// File: rtl/hs_link_pkg.sv
package hs_link_pkg;
  typedef enum logic [2:0] {
    M_IDLE, M_ADEC, M_AREQ, M_AREL, M_DSET, M_DREQ, M_DREL
  } m_state_e;

  typedef enum logic [1:0] {
    S_AWAIT, S_AACK, S_DWAIT, S_DACK
  } s_state_e;
endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/hs_master.sv
module hs_master
  import hs_link_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int DECODE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              req_o,
  output logic              rd_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] ad_o,
  input  logic [DATA_W-1:0] ad_i,
  input  logic              ack_i
);
  localparam int DEC_CW = $clog2(DECODE_CYC + 1);
  localparam logic [DEC_CW-1:0] DEC_LAST = DEC_CW'(DECODE_CYC - 1);
  localparam logic [DEC_CW-1:0] DEC_FULL = DEC_CW'(DECODE_CYC);

  function automatic logic [DATA_W-1:0] addr_on_bus(input logic [ADDR_W-1:0] a);
    return DATA_W'(a);
  endfunction

  m_state_e          state;
  logic [DEC_CW-1:0] dec_cnt;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              ack_s;

  hs_sync2 #(.W(1)) u_ack_sync (.clk(clk), .rst_n(rst_n), .d(ack_i), .q(ack_s));

  assign cmd_ready = (state == M_IDLE) && !ack_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= M_IDLE;
      dec_cnt <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      req_o   <= 1'b0;
      rd_o    <= 1'b0;
      oe_o    <= 1'b0;
      ad_o    <= '0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        M_IDLE: if (cmd_valid && cmd_ready) begin
          wr_q    <= cmd_write;
          wdata_q <= cmd_wdata;
          rd_o    <= !cmd_write;
          ad_o    <= addr_on_bus(cmd_addr);
          oe_o    <= 1'b1;
          dec_cnt <= '0;
          state   <= M_ADEC;
        end
        M_ADEC: begin
          if (dec_cnt == DEC_LAST) begin
            req_o <= 1'b1;
            state <= M_AREQ;
          end else begin
            dec_cnt <= dec_cnt + 1'b1;
          end
        end
        M_AREQ: if (ack_s) begin
          req_o <= 1'b0;
          oe_o  <= 1'b0;
          ad_o  <= '0;
          state <= M_AREL;
        end
        M_AREL: if (!ack_s) begin
          if (wr_q) begin
            oe_o <= 1'b1;
            ad_o <= wdata_q;
          end
          state <= M_DSET;
        end
        M_DSET: begin
          req_o <= 1'b1;
          state <= M_DREQ;
        end
        M_DREQ: if (ack_s) begin
          req_o <= 1'b0;
          if (!wr_q) rdata <= ad_i;
          oe_o  <= 1'b0;
          ad_o  <= '0;
          state <= M_DREL;
        end
        M_DREL: if (!ack_s) begin
          done  <= 1'b1;
          state <= M_IDLE;
        end
        default: state <= M_IDLE;
      endcase
    end
  end

  // Checker-side age of the driven address, counted independently of dec_cnt
  logic [DEC_CW-1:0] addr_age;
  logic              in_addr_req;
  assign in_addr_req = (state == M_AREQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 addr_age <= '0;
    else if (state == M_IDLE)   addr_age <= '0;
    else if (addr_age != DEC_FULL && state == M_ADEC) addr_age <= addr_age + 1'b1;
  end

  // R2
  decode_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) && in_addr_req |-> addr_age >= DEC_FULL);
  // R3
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> !$past(ack_s));
  // R3
  req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_o) |-> $past(ack_s));
  // R5
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && $past(req_o) |-> $stable(ad_o) && $stable(rd_o));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !$past(ack_s));
endmodule

// File: rtl/hs_slave.sv
module hs_slave
  import hs_link_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ack_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] ad_o
);
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [ADDR_W-1:0] bus_to_addr(input logic [DATA_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  s_state_e          state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] store [DEPTH];
  logic              req_s;

  hs_sync2 #(.W(1)) u_req_sync (.clk(clk), .rst_n(rst_n), .d(req_i), .q(req_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_AWAIT;
      addr_q <= '0;
      ack_o  <= 1'b0;
      oe_o   <= 1'b0;
      ad_o   <= '0;
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      unique case (state)
        S_AWAIT: if (req_s) begin
          addr_q <= bus_to_addr(ad_i);
          ack_o  <= 1'b1;
          state  <= S_AACK;
        end
        S_AACK: if (!req_s) begin
          ack_o <= 1'b0;
          state <= S_DWAIT;
        end
        S_DWAIT: if (req_s) begin
          if (rd_i) begin
            ad_o <= store[addr_q];
            oe_o <= 1'b1;
          end else begin
            store[addr_q] <= ad_i;
          end
          ack_o <= 1'b1;
          state <= S_DACK;
        end
        S_DACK: if (!req_s) begin
          ack_o <= 1'b0;
          oe_o  <= 1'b0;
          ad_o  <= '0;
          state <= S_AWAIT;
        end
        default: state <= S_AWAIT;
      endcase
    end
  end

  // R4
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(req_s));
  // R4
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> !$past(req_s));
endmodule

// File: rtl/hs_link_top.sv
module hs_link_top #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int DECODE_CYC = 3
) (
  input  logic              clk_m,
  input  logic              rst_m_n,
  input  logic              clk_s,
  input  logic              rst_s_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] bus_ad,
  output logic              bus_rd,
  output logic              bus_req,
  output logic              bus_ack
);
  logic              m_oe, s_oe;
  logic [DATA_W-1:0] m_ad, s_ad;

  // Shared lines: whichever side enables its driver owns them
  assign bus_ad = m_oe ? m_ad : (s_oe ? s_ad : '0);

  hs_master #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DECODE_CYC(DECODE_CYC)) u_master (
    .clk(clk_m), .rst_n(rst_m_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready), .done(done), .rdata(rdata),
    .req_o(bus_req), .rd_o(bus_rd), .oe_o(m_oe), .ad_o(m_ad),
    .ad_i(bus_ad), .ack_i(bus_ack)
  );

  hs_slave #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_slave (
    .clk(clk_s), .rst_n(rst_s_n),
    .req_i(bus_req), .rd_i(bus_rd), .ad_i(bus_ad),
    .ack_o(bus_ack), .oe_o(s_oe), .ad_o(s_ad)
  );

  // R9
  one_driver_m_chk: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    !(m_oe && s_oe));
  // R9
  one_driver_s_chk: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    !(m_oe && s_oe));
endmodule

// File: tb/hs_link_tb.sv
module hs_link_top_tb_top;
  localparam int DW  = 16;
  localparam int AW  = 3;
  localparam int DEC = 4;

  logic clk_m = 1'b0, clk_s = 1'b0, rst_m_n = 1'b0, rst_s_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, done, bus_rd, bus_req, bus_ack;
  logic [DW-1:0] rdata, bus_ad;

  int checks = 0, failures = 0, req_rises = 0;
  logic req_prev = 1'b0;
  logic [DW-1:0] ref_mem [1 << AW];

  always #5 clk_m = ~clk_m;
  always #7 clk_s = ~clk_s;

  hs_link_top #(.DATA_W(DW), .ADDR_W(AW), .DECODE_CYC(DEC)) dut_i (
    .clk_m(clk_m), .rst_m_n(rst_m_n), .clk_s(clk_s), .rst_s_n(rst_s_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready), .done(done), .rdata(rdata),
    .bus_ad(bus_ad), .bus_rd(bus_rd), .bus_req(bus_req), .bus_ack(bus_ack)
  );

  function automatic logic [DW-1:0] widen_addr(input logic [AW-1:0] a);
    logic [DW-1:0] w = '0;
    for (int b = 0; b < AW; b++) w[b] = a[b];
    return w;
  endfunction

  always @(negedge clk_m) begin
    if (bus_req && !req_prev) req_rises++;
    req_prev <= bus_req;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_req(input logic lvl);
    while (bus_req !== lvl) @(negedge clk_m);
  endtask

  task automatic do_cmd(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit poke_busy);
    int n = 0;
    int rises0;
    logic [DW-1:0] exp;
    exp = ref_mem[a];
    @(negedge clk_m);
    while (!cmd_ready) @(negedge clk_m);
    rises0 = req_rises;
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(posedge clk_m);
    @(negedge clk_m);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R10", "ready during transaction", DW'(cmd_ready), '0);
    if (poke_busy) begin
      cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = ~d;
    end
    while (!bus_req) begin
      n++;
      @(negedge clk_m);
    end
    cmd_valid = 1'b0;
    // n counts clk_m edges after the acceptance edge until request is seen
    check(n == DEC, "R2", "decode gap", DW'(n), DW'(DEC));
    check(bus_ad == widen_addr(a), "R8", "address phase lines", bus_ad, widen_addr(a));
    check(bus_rd == !wr, "R5", "direction line", DW'(bus_rd), DW'(!wr));
    wait_req(1'b0);
    wait_req(1'b1);
    if (wr) check(bus_ad == d, "R6", "write word on lines", bus_ad, d);
    while (!done) @(negedge clk_m);
    check(req_rises - rises0 == 2, "R8", "request rises per transaction",
          DW'(req_rises - rises0), DW'(2));
    check(cmd_ready == 1'b1, "R11", "ready with done", DW'(cmd_ready), 1);
    if (!wr) check(rdata == exp, "R7", "read word", rdata, exp);
    else ref_mem[a] = d;
    @(negedge clk_m);
    check(done == 1'b0, "R11", "done single cycle", DW'(done), '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_m);
    checks++; failures++;
    $display("FAIL R3 watchdog expired: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk_m);
    // R1 reset state
    check(bus_req == 0 && bus_ack == 0, "R1", "handshake lines in reset",
          DW'({bus_req, bus_ack}), '0);
    check(done == 0, "R1", "done in reset", DW'(done), '0);
    check(bus_ad == '0, "R1", "lines in reset", bus_ad, '0);
    check(cmd_ready == 1, "R1", "ready in reset", DW'(cmd_ready), 1);
    rst_m_n = 1'b1; rst_s_n = 1'b1;
    repeat (2) @(negedge clk_m);

    // Directed: read unwritten (R7), edge addresses, all-ones and zero data
    do_cmd(1'b0, 3'd5, '0, 1'b0);
    do_cmd(1'b1, 3'd0, 16'hFFFF, 1'b0);
    do_cmd(1'b1, 3'd7, 16'h0000, 1'b0);
    do_cmd(1'b0, 3'd0, '0, 1'b0);
    do_cmd(1'b0, 3'd7, '0, 1'b0);
    do_cmd(1'b1, 3'd7, 16'hA5C3, 1'b0);
    do_cmd(1'b0, 3'd7, '0, 1'b0);
    // R10: cmd_valid while busy must not reach the target
    do_cmd(1'b1, 3'd2, 16'h1234, 1'b1);
    do_cmd(1'b0, 3'd2, '0, 1'b0);
    do_cmd(1'b0, 3'd5, '0, 1'b1);
    do_cmd(1'b0, 3'd5, '0, 1'b0);

    // Random traffic
    for (int k = 0; k < 60; k++) begin
      do_cmd(1'($urandom), AW'($urandom), DW'($urandom), 1'b0);
    end
    // Final sweep of every location (R6, R7)
    for (int k = 0; k < (1 << AW); k++) do_cmd(1'b0, AW'(k), '0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule